// File: doc/BRIEF.md
# Chip-Wide Power, Reset and Output-Enable Controller

This block keeps a handful of global control registers and turns them into the power, reset and pad-enable signals for a digital core. Software writes and reads the registers through a plain request port. Every request gets one response cycle with either an acknowledge or a refusal. The block decides where power-down comes from. Out of reset an external pin rules it, and once a select bit is set a register bit rules it instead. While power-down is active the core clock is stopped by a glitch-free gate, and the register port keeps running on the ungated clock.

Writing the reset-request bit starts a timed soft-reset sequence. It behaves like the external reset pin: registers that have a defined default return to it, the core reset is held low for a parameterised number of clock cycles, and the request bit clears itself. The write that starts the sequence is refused, and so is every access made while it runs. A small retained field has no reset value and keeps its contents through a soft reset. Output enables are produced per pin group: data pins, timing pins, a frame-sync pin and the line-locked clock pin. The timing pins can be forced to stay driven while the other groups are tristated.

Top module: `glob_ctl`

## Requirements
- R1: After the reset pin is released, address 0x0F, address 0x03 and bit 7 of address 0x1D read as 0. All output enables are 1, `pdn_o` is 0 and `core_rst_no` is 1. While the pin is low, `core_rst_no` is 0.
- R2: A request is sampled on a rising clock edge. In the following cycle exactly one of `ack_o`/`nak_o` is 1, for one cycle, and a read places its data on `rdata_o` in that cycle. The readable fields are 0x0F bit 2 (source select), 0x0F bit 5 (power-down request), 0x03 bit 6 (output tristate), 0x03 bit 3 (timing-pin force), 0x1D bit 7 (clock-pin tristate) and 0x1D bits 4:0 (retained field). All other bits read 0.
- R3: With 0x0F bit 2 at 0, `pdn_o` follows the external `pdn_pin_i`, and 0x0F bit 5 has no effect.
- R4: With 0x0F bit 2 at 1, `pdn_o` follows 0x0F bit 5, and `pdn_pin_i` has no effect.
- R5: While `pdn_o` is 1, `core_clk_o` has no rising edges, and register reads and writes are still acknowledged and take effect.
- R6: Power-down ends when 0x0F bit 5 is written back to 0 (with bit 2 at 1) or when a soft reset runs.
- R7: A write of 0x0F with bit 7 at 1 is refused with `nak_o`. Its other data bits are discarded, every register field with a default returns to 0, and bit 7 reads 0 afterwards.
- R8: After the starting write, `core_rst_no` stays 0 for exactly RST_CYCLES cycles. Any access sampled in that time is refused and has no effect.
- R9: The retained field at 0x1D bits 4:0 keeps its value through a soft reset.
- R10: With 0x03 bit 6 at 1, every data enable, `sfl_oe_o` and `sync_oe_o` are 0. With 0x03 bit 3 also at 1, `sync_oe_o` stays 1.
- R11: `llc_oe_o` is 0 exactly when 0x1D bit 7 is 1.
- R12: A write to any other address is acknowledged and changes nothing, and a read of it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock for the register port and the sequencer |
| rst_ni | input | 1 | Asynchronous active-low reset pin |
| pdn_pin_i | input | 1 | External power-down pin, active high, asynchronous |
| wr_en_i | input | 1 | Write request |
| rd_en_i | input | 1 | Read request, ignored when wr_en_i is also 1 |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the response cycle |
| ack_o | output | 1 | Request accepted |
| nak_o | output | 1 | Request refused |
| core_clk_o | output | 1 | Gated core clock |
| core_rst_no | output | 1 | Active-low core reset |
| pdn_o | output | 1 | Power-down state |
| data_oe_o | output | DATA_W | Per-pin data output enables |
| sync_oe_o | output | 1 | Enable for the horizontal/vertical/field timing pins |
| sfl_oe_o | output | 1 | Enable for the frame-sync pin |
| llc_oe_o | output | 1 | Enable for the line-locked clock pin |

## Verification
The bench goes after the power-down source select. A design that decoded the select backwards, or let both sources act together, would power down on the wrong input in the vector table. It counts the soft-reset window cycle by cycle: an off-by-one counter would hold the core reset one cycle too long or too short. It also sends a write in the middle of that window, and a design that still accepted it would leave the tristate bit set. The retained field is read back after a soft reset, so a design that cleared it, or failed to clear its neighbours, shows up. A core counter clocked by the gated clock is watched during power-down, so a gate that leaks an edge or stalls the register port is caught.

// File: rtl/glob_ctl_pkg.sv
package glob_ctl_pkg;

  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;
  localparam int unsigned KEEP_W = 5;

  localparam logic [AW-1:0] ADDR_PWR = 8'h0F;
  localparam logic [AW-1:0] ADDR_OUT = 8'h03;
  localparam logic [AW-1:0] ADDR_CLK = 8'h1D;

  // bit positions decoded by software
  localparam int unsigned B_PD_SEL = 2;
  localparam int unsigned B_PD_REQ = 5;
  localparam int unsigned B_RST    = 7;
  localparam int unsigned B_HIZ    = 6;
  localparam int unsigned B_FORCE  = 3;
  localparam int unsigned B_CKHIZ  = 7;

  typedef struct packed {
    logic pd_sel;
    logic pd_req;
    logic out_hiz;
    logic sync_force;
    logic clk_hiz;
  } ctl_t;

  localparam ctl_t CTL_DEF = '{pd_sel: 1'b0, pd_req: 1'b0, out_hiz: 1'b0,
                               sync_force: 1'b0, clk_hiz: 1'b0};

endpackage

// File: rtl/glob_ctl_regs.sv
module glob_ctl_regs
  import glob_ctl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  output logic [DW-1:0] rdata_o,
  output logic          ack_o,
  output logic          nak_o,
  output logic          start_o,
  output ctl_t          ctl_o
);

  ctl_t              ctl_q, ctl_d;
  logic [KEEP_W-1:0] keep_q;
  logic [DW-1:0]     rdata_d, rd_mux;
  logic              ack_d, nak_d;
  logic              req, trig, wr_ok, rd_ok, keep_we;

  assign req   = wr_en_i | rd_en_i;
  assign trig  = wr_en_i & ~busy_i & (addr_i == ADDR_PWR) & wdata_i[B_RST];
  assign wr_ok = wr_en_i & ~busy_i & ~trig;
  assign rd_ok = rd_en_i & ~wr_en_i & ~busy_i;
  assign keep_we = wr_ok & (addr_i == ADDR_CLK);

  // next-state of the resettable control fields
  always_comb begin
    ctl_d = ctl_q;
    if (trig) begin
      ctl_d = CTL_DEF;
    end else if (wr_ok) begin
      unique case (addr_i)
        ADDR_PWR: begin
          ctl_d.pd_sel = wdata_i[B_PD_SEL];
          ctl_d.pd_req = wdata_i[B_PD_REQ];
        end
        ADDR_OUT: begin
          ctl_d.out_hiz    = wdata_i[B_HIZ];
          ctl_d.sync_force = wdata_i[B_FORCE];
        end
        ADDR_CLK: ctl_d.clk_hiz = wdata_i[B_CKHIZ];
        default:  ctl_d = ctl_q;
      endcase
    end
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      ADDR_PWR: begin
        rd_mux[B_PD_SEL] = ctl_q.pd_sel;
        rd_mux[B_PD_REQ] = ctl_q.pd_req;
      end
      ADDR_OUT: begin
        rd_mux[B_HIZ]   = ctl_q.out_hiz;
        rd_mux[B_FORCE] = ctl_q.sync_force;
      end
      ADDR_CLK: begin
        rd_mux[B_CKHIZ]    = ctl_q.clk_hiz;
        rd_mux[KEEP_W-1:0] = keep_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_comb begin
    rdata_d = rd_ok ? rd_mux : '0;
    ack_d   = req & ~busy_i & ~trig;
    nak_d   = req & (busy_i | trig);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= CTL_DEF;
      rdata_o <= '0;
      ack_o   <= 1'b0;
      nak_o   <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      rdata_o <= rdata_d;
      ack_o   <= ack_d;
      nak_o   <= nak_d;
    end
  end

  // retained field: no reset value, survives both resets
  always_ff @(posedge clk_i) begin
    if (keep_we) begin
      keep_q <= wdata_i[KEEP_W-1:0];
    end
  end

  assign start_o = trig;
  assign ctl_o   = ctl_q;

  assert_one_resp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_o && nak_o));

  assert_req_resp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req |=> (ack_o || nak_o));

  assert_trig_refused_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (nak_o && !ctl_o.pd_req && !ctl_o.pd_sel && !ctl_o.out_hiz));

  assert_busy_refused_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && busy_i) |=> (nak_o && $stable(ctl_o)));

endmodule

// File: rtl/glob_ctl_rstseq.sv
module glob_ctl_rstseq #(
  parameter int unsigned RST_CYCLES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);

  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i) begin
      cnt_d = LOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (cnt_q != '0);

  assert_start_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_rise_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && busy_o));

endmodule

// File: rtl/glob_ctl_cgate.sv
module glob_ctl_cgate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_i,
  output logic clk_o,
  output logic en_o
);

  logic en_q, en_d, en_lat;

  assign en_d = ~pd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b1;
    end else begin
      en_q <= en_d;
    end
  end

  // transparent while the clock is low, so the enable cannot change mid-pulse
  always_latch begin
    if (!clk_i) begin
      en_lat = en_q;
    end
  end

  assign clk_o = clk_i & en_lat;
  assign en_o  = en_q;

  assert_gate_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> !en_o);

endmodule

// File: rtl/glob_ctl_oe.sv
module glob_ctl_oe #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              out_hiz_i,
  input  logic              sync_force_i,
  input  logic              clk_hiz_i,
  output logic [DATA_W-1:0] data_oe_o,
  output logic              sync_oe_o,
  output logic              sfl_oe_o,
  output logic              llc_oe_o
);

  logic sync_d, sfl_d, llc_d;

  // one registered enable per data pin
  for (genvar g = 0; g < DATA_W; g++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_oe_o[g] <= 1'b1;
      end else begin
        data_oe_o[g] <= ~out_hiz_i;
      end
    end
  end

  always_comb begin
    sync_d = ~out_hiz_i | sync_force_i;
    sfl_d  = ~out_hiz_i;
    llc_d  = ~clk_hiz_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_oe_o <= 1'b1;
      sfl_oe_o  <= 1'b1;
      llc_oe_o  <= 1'b1;
    end else begin
      sync_oe_o <= sync_d;
      sfl_oe_o  <= sfl_d;
      llc_oe_o  <= llc_d;
    end
  end

  assert_force_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_force_i |=> sync_oe_o);

  assert_hiz_group_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_hiz_i |=> (!sfl_oe_o && !data_oe_o[0]));

endmodule

// File: rtl/glob_ctl.sv
module glob_ctl
  import glob_ctl_pkg::*;
#(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned RST_CYCLES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pdn_pin_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [7:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              ack_o,
  output logic              nak_o,
  output logic              core_clk_o,
  output logic              core_rst_no,
  output logic              pdn_o,
  output logic [DATA_W-1:0] data_oe_o,
  output logic              sync_oe_o,
  output logic              sfl_oe_o,
  output logic              llc_oe_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic [1:0] pin_sync_q;
  logic       pin_s;
  logic       start, busy, pd_act, clk_en;
  ctl_t       ctl;

  // async assert, sync release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      pin_sync_q <= 2'b00;
    end else begin
      pin_sync_q <= {pin_sync_q[0], pdn_pin_i};
    end
  end
  assign pin_s = pin_sync_q[1];

  glob_ctl_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .busy_i  (busy),
    .rdata_o (rdata_o),
    .ack_o   (ack_o),
    .nak_o   (nak_o),
    .start_o (start),
    .ctl_o   (ctl)
  );

  glob_ctl_rstseq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .start_i (start),
    .busy_o  (busy)
  );

  assign pd_act = ctl.pd_sel ? ctl.pd_req : pin_s;

  glob_ctl_cgate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .pd_i   (pd_act),
    .clk_o  (core_clk_o),
    .en_o   (clk_en)
  );

  glob_ctl_oe #(.DATA_W(DATA_W)) u_oe (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .out_hiz_i    (ctl.out_hiz),
    .sync_force_i (ctl.sync_force),
    .clk_hiz_i    (ctl.clk_hiz),
    .data_oe_o    (data_oe_o),
    .sync_oe_o    (sync_oe_o),
    .sfl_oe_o     (sfl_oe_o),
    .llc_oe_o     (llc_oe_o)
  );

  assign pdn_o       = ~clk_en;
  assign core_rst_no = rst_n & ~busy;

  assert_pin_rules_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!ctl.pd_sel && !pin_s) |=> !pdn_o);

  assert_bit_rules_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ctl.pd_sel && !ctl.pd_req) |=> !pdn_o);

  assert_soft_wake_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start && !pin_s) |=> ##1 !pdn_o);

endmodule

// File: tb/sim_glob_ctl.sv
module sim_glob_ctl;

  localparam int DATA_W = 16;
  localparam int RST_CYCLES = 32;

  // {reg03, reg1D, reg0F, pin, 2'b0, pdn, data_oe, sync_oe, sfl_oe, llc_oe}
  localparam logic [31:0] VEC [9] = '{
    32'h0000000F, 32'h40000001, 32'h48000005, 32'h0880000E, 32'h0000200F,
    32'h0000009F, 32'h0000241F, 32'h0000048F, 32'h40802490
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pin = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [7:0]        addr = '0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic              ack, nak, core_clk, core_rst_n, pdn;
  logic [DATA_W-1:0] data_oe;
  logic              sync_oe, sfl_oe, llc_oe;

  int checks = 0;
  int errors = 0;
  int core_cnt = 0;

  always #10 clk = ~clk;

  always @(posedge core_clk) core_cnt <= core_cnt + 1;

  glob_ctl #(.DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pdn_pin_i(pin),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ack_o(ack), .nak_o(nak),
    .core_clk_o(core_clk), .core_rst_no(core_rst_n), .pdn_o(pdn),
    .data_oe_o(data_oe), .sync_oe_o(sync_oe), .sfl_oe_o(sfl_oe), .llc_oe_o(llc_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d,
                        output logic ok, output logic no);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    ok = ack; no = nak;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d,
                        output logic ok, output logic no);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata; ok = ack; no = nak;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ok, no;
    logic [7:0] rd;
    int snap;
    int n;

    // R1: state while and after the reset pin
    wait_cyc(3);
    chk("R1 core reset during pin reset", core_rst_n, 0);
    rst_n = 1'b1;
    wait_cyc(4);
    chk("R1 core_rst_no", core_rst_n, 1);
    chk("R1 pdn_o", pdn, 0);
    chk("R1 data_oe", data_oe, 16'hFFFF);
    chk("R1 other oe", {sync_oe, sfl_oe, llc_oe}, 3'b111);
    bus_rd(8'h0F, rd, ok, no);
    chk("R1 reg 0x0F", rd, 8'h00);
    chk("R2 read ack", {ok, no}, 2'b10);
    bus_rd(8'h03, rd, ok, no);
    chk("R1 reg 0x03", rd, 8'h00);
    bus_rd(8'h1D, rd, ok, no);
    chk("R1 reg 0x1D bit7", rd[7], 1'b0);

    // R2: field positions
    bus_wr(8'h03, 8'hFF, ok, no);
    chk("R2 write ack", {ok, no}, 2'b10);
    bus_rd(8'h03, rd, ok, no);
    chk("R2 0x03 fields", rd, 8'h48);
    bus_wr(8'h0F, 8'h7F, ok, no);
    bus_rd(8'h0F, rd, ok, no);
    chk("R2 0x0F fields", rd, 8'h24);
    bus_wr(8'h1D, 8'h8A, ok, no);
    bus_rd(8'h1D, rd, ok, no);
    chk("R2 0x1D fields", rd, 8'h8A);
    @(negedge clk);
    chk("R2 response one cycle", {ack, nak}, 2'b00);

    // R12: unmapped address
    bus_wr(8'h44, 8'hFF, ok, no);
    chk("R12 unmapped write ack", {ok, no}, 2'b10);
    bus_rd(8'h44, rd, ok, no);
    chk("R12 unmapped read", rd, 8'h00);
    bus_rd(8'h03, rd, ok, no);
    chk("R12 no side effect", rd, 8'h48);

    // R3 R4 R10 R11 vector table
    for (int i = 0; i < 9; i++) begin
      logic [31:0] v;
      v = VEC[i];
      bus_wr(8'h03, v[31:24], ok, no);
      bus_wr(8'h1D, v[23:16], ok, no);
      bus_wr(8'h0F, v[15:8], ok, no);
      pin = v[7];
      wait_cyc(6);
      chk($sformatf("R3 R4 pdn vec%0d", i), pdn, v[4]);
      chk($sformatf("R10 data_oe vec%0d", i), data_oe, {DATA_W{v[3]}});
      chk($sformatf("R10 sync_oe vec%0d", i), sync_oe, v[2]);
      chk($sformatf("R10 sfl_oe vec%0d", i), sfl_oe, v[1]);
      chk($sformatf("R11 llc_oe vec%0d", i), llc_oe, v[0]);
    end
    pin = 1'b0;
    bus_wr(8'h0F, 8'h00, ok, no);
    bus_wr(8'h03, 8'h00, ok, no);
    bus_wr(8'h1D, 8'h00, ok, no);
    wait_cyc(4);

    // R5: core frozen, port alive
    bus_wr(8'h0F, 8'h24, ok, no);
    wait_cyc(4);
    chk("R5 pdn_o set", pdn, 1);
    snap = core_cnt;
    bus_wr(8'h1D, 8'h15, ok, no);
    chk("R5 write during power-down", {ok, no}, 2'b10);
    bus_rd(8'h1D, rd, ok, no);
    chk("R5 read during power-down", rd, 8'h15);
    wait_cyc(10);
    chk("R5 core clock stopped", core_cnt, snap);

    // R6: wake by clearing the bit
    bus_wr(8'h0F, 8'h04, ok, no);
    wait_cyc(4);
    chk("R6 pdn_o cleared", pdn, 0);
    snap = core_cnt;
    wait_cyc(5);
    chk("R6 core clock runs", (core_cnt != snap), 1);

    // R7 R8 R9: soft reset with length count
    bus_wr(8'h03, 8'h48, ok, no);
    bus_wr(8'h1D, 8'h8C, ok, no);
    bus_wr(8'h0F, 8'h24, ok, no);
    wait_cyc(4);
    chk("R6 pdn before soft reset", pdn, 1);
    bus_wr(8'h0F, 8'hA4, ok, no);
    chk("R7 trigger refused", {ok, no}, 2'b01);
    n = 0;
    while (!core_rst_n && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk("R8 reset window length", n, RST_CYCLES);
    wait_cyc(3);
    chk("R6 pdn after soft reset", pdn, 0);
    bus_rd(8'h0F, rd, ok, no);
    chk("R7 0x0F defaults, bit7 clear", rd, 8'h00);
    bus_rd(8'h03, rd, ok, no);
    chk("R7 0x03 defaults", rd, 8'h00);
    bus_rd(8'h1D, rd, ok, no);
    chk("R9 retained field kept", rd, 8'h0C);
    chk("R10 oe after soft reset", {sync_oe, sfl_oe, llc_oe}, 3'b111);

    // R8: access refused inside the window
    bus_wr(8'h0F, 8'h80, ok, no);
    bus_wr(8'h03, 8'h40, ok, no);
    chk("R8 write refused in window", {ok, no}, 2'b01);
    bus_rd(8'h1D, rd, ok, no);
    chk("R8 read refused in window", {ok, no, rd}, {2'b01, 8'h00});
    while (!core_rst_n) @(negedge clk);
    bus_rd(8'h03, rd, ok, no);
    chk("R8 refused write discarded", rd, 8'h00);
    wait_cyc(3);
    chk("R8 data_oe untouched", data_oe, 16'hFFFF);

    // R1: pin reset mid-operation
    bus_wr(8'h03, 8'h40, ok, no);
    wait_cyc(3);
    chk("R10 data off before pin reset", data_oe, 16'h0000);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 core reset on pin", core_rst_n, 0);
    chk("R1 oe restored on pin", data_oe, 16'hFFFF);
    rst_n = 1'b1;
    wait_cyc(4);
    bus_rd(8'h03, rd, ok, no);
    chk("R1 0x03 after pin reset", rd, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule